// File: doc/BRIEF.md
# Reset Cause Status and Control Register

This block holds one 32-bit register, reached over a simple register bus, that reports why the system last came out of reset. Software can also use it to ask for a reset. Only the top five bits exist. Three of them are status flags that software clears by writing a one: power-on, button power-on and button externally-initiated. The other two are request flags that software sets by writing a one: soft power-on and soft externally-initiated.

Writing a one to either request flag produces a one-cycle `resetReq` pulse in the following cycle. The system reset logic returns each reset it performs to the block on `resetEvt`. A saturating counter tracks how many reset events have been seen since it was last cleared.

When a reset event arrives while that count is zero, the register is loaded with the power-on flag alone. The hardware `porN` input clears the count, and so does a soft power-on request. Either one rearms power-on detection, so the next reset again reports a power-on.

Top module: `rst_cause_reg`

## Requirements
- R1: While `porN` is low, the register and the reset counter are cleared. Once `porN` goes high, reads return 0 until the first event.
- R2: The register is selected only when `busAddr[15:3]` equals `REG_BASE[15:3]` (0xF020) and `busAddr[2]` is 1. Any other read returns 0, and any other write has no effect.
- R3: Written data is masked to bits 31:27. Bits 26:0 always read as 0.
- R4: Bits 31 (power-on), 28 (button power-on) and 27 (button externally-initiated) are cleared where the write data holds a one. A zero leaves them unchanged, and writing never sets them.
- R5: Bits 30 (soft power-on) and 29 (soft externally-initiated) are set where the write data holds a one. A zero leaves them unchanged.
- R6: A selected write with bit 30 set clears the reset counter to zero. It also raises `resetReq` in the next cycle.
- R7: A selected write with bit 29 set and bit 30 clear raises `resetReq` in the next cycle. The counter is not touched.
- R8: `resetReq` is high for exactly the one cycle after a write of R6 or R7, and is low at every other time.
- R9: When `resetEvt` arrives with the counter at zero, the register becomes exactly 0x80000000. With a non-zero counter, the event leaves the register unchanged. Every event increments the counter.
- R10: The counter saturates at 2^CNT_W-1 and never wraps back to zero, so a long run of resets never reports a false power-on.
- R11: When `resetEvt` is high, a write in the same cycle is discarded. It changes neither the register nor the counter, and it produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Hardware power-on, active low, asynchronous clear |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, 0 when not selected |
| resetEvt | input | 1 | One cycle per system reset performed |
| resetReq | output | 1 | One-cycle reset request pulse |

## Verification
The bench runs with `resetReq` both looped back onto `resetEvt` and detached from it. In the looped-back case, a soft power-on is overwritten by the power-on code on the very next edge. A design that failed to rearm detection on a soft power-on would leave bit 30 visible instead.

Reads at the word with bit 2 clear and at the neighbouring word must return zero; a loose decode would show the register there. Events forced in the same cycle as a write check that the write is dropped.

A run of more than 2^CNT_W events followed by clearing the status bits checks saturation. A wrapping counter would report a false power-on on the next event.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam logic [31:0] IMPL_MASK = 32'hF800_0000;
  localparam logic [31:0] CLR_MASK  = 32'h9800_0000;
  localparam logic [31:0] SET_MASK  = 32'h6000_0000;
  localparam logic [31:0] POR_VALUE = 32'h8000_0000;
  localparam int SOFT_POR_BIT = 30;
  localparam int SOFT_XIR_BIT = 29;
  localparam int WORD_SEL_BIT = 2;

  typedef struct packed {
    logic regWrite;
    logic loadPor;
    logic rdSel;
  } strobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 'hF020,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              resetEvt,
  output strobe_t           stb,
  output logic              resetReq
);
  localparam int BLK_LSB = WORD_SEL_BIT + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntQ;
  logic blockHit, wordHit, wrHit, softPor, softXir;

  assign blockHit = (busAddr[ADDR_W-1:BLK_LSB] == REG_BASE[ADDR_W-1:BLK_LSB]);
  assign wordHit  = blockHit & busAddr[WORD_SEL_BIT];
  // a reset event aborts a write landing in the same cycle
  assign wrHit    = busWr & wordHit & ~resetEvt;
  assign softPor  = wrHit & busWdata[SOFT_POR_BIT];
  assign softXir  = wrHit & busWdata[SOFT_XIR_BIT];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cntQ <= '0;
    end else if (resetEvt) begin
      if (cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
    end else if (softPor) begin
      cntQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) resetReq <= 1'b0;
    else       resetReq <= softPor | softXir;
  end

  always_comb begin
    stb.regWrite = wrHit;
    stb.loadPor  = resetEvt & (cntQ == '0);
    stb.rdSel    = busRd & wordHit;
  end

  // R10
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!porN)
    (resetEvt && cntQ == CNT_MAX) |=> cntQ == CNT_MAX);
  // R6
  soft_por_rearm_chk: assert property (@(posedge clk) disable iff (!porN)
    (busWr && wordHit && !resetEvt && busWdata[SOFT_POR_BIT]) |=> (cntQ == '0 && resetReq));
  // R8
  req_only_after_write_chk: assert property (@(posedge clk) disable iff (!porN)
    !(busWr && wordHit && !resetEvt && (busWdata[SOFT_POR_BIT] || busWdata[SOFT_XIR_BIT]))
      |=> !resetReq);
  // R11
  evt_blocks_write_chk: assert property (@(posedge clk) disable iff (!porN)
    resetEvt |-> !stb.regWrite);
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  strobe_t     stb,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);
  logic [31:0] regQ;
  logic [31:0] wData;

  assign wData = busWdata & IMPL_MASK;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      regQ <= '0;
    end else if (stb.loadPor) begin
      regQ <= POR_VALUE;
    end else if (stb.regWrite) begin
      regQ <= (regQ & ~(wData & CLR_MASK)) | (wData & SET_MASK);
    end
  end

  assign busRdata = stb.rdSel ? regQ : '0;

  // R9
  por_load_chk: assert property (@(posedge clk) disable iff (!porN)
    stb.loadPor |=> regQ == POR_VALUE);
  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!porN)
    (stb.regWrite && !stb.loadPor && busWdata[31]) |=> !regQ[31]);
  // R5
  w1s_chk: assert property (@(posedge clk) disable iff (!porN)
    (stb.regWrite && !stb.loadPor && busWdata[SOFT_XIR_BIT]) |=> regQ[SOFT_XIR_BIT]);
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!porN)
    (regQ & ~IMPL_MASK) == '0);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 'hF020,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              resetEvt,
  output logic              resetReq
);
  strobe_t stb;

  rst_cause_ctrl #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .porN(porN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .resetEvt(resetEvt), .stb(stb), .resetReq(resetReq)
  );

  rst_cause_dp u_dp (
    .clk(clk), .porN(porN), .stb(stb), .busWdata(busWdata), .busRdata(busRdata)
  );

  // R2
  low_word_zero_chk: assert property (@(posedge clk) disable iff (!porN)
    (busRd && !busAddr[WORD_SEL_BIT]) |-> busRdata == '0);
endmodule

// File: tb/rst_cause_reg_bench.sv
`timescale 1ns/1ps
module rst_cause_reg_bench;
  localparam int CNT_MAX = 15;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic resetReq;
  logic loopEn = 1'b0, evtForce = 1'b0;
  logic resetEvt;

  int checks = 0, fails = 0;
  logic [31:0] expReg = '0;
  int expCnt = 0;
  bit expReq = 1'b0;

  always #2 clk = ~clk;
  assign resetEvt = evtForce | (loopEn & resetReq);

  rst_cause_reg u_rst_cause_reg (
    .clk(clk), .porN(porN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .resetEvt(resetEvt), .resetReq(resetReq)
  );

  function automatic bit selWord(input logic [15:0] a);
    return (a[15:3] == 13'h1E04) && a[2];
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit wr, input bit rd, input logic [15:0] a,
                     input logic [31:0] d, input bit frc, input string req);
    logic [31:0] nReg, m;
    int nCnt;
    bit nReq, evt;
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busWdata = d; evtForce = frc;
    #1;
    check32("R8", {31'd0, resetReq}, {31'd0, expReq});
    if (rd) check32(req, busRdata, selWord(a) ? expReg : 32'h0);
    evt = frc | (loopEn & expReq);
    nReg = expReg; nCnt = expCnt; nReq = 1'b0;
    if (evt) begin
      if (expCnt == 0) nReg = 32'h8000_0000;
      if (expCnt < CNT_MAX) nCnt = expCnt + 1;
    end else if (wr && selWord(a)) begin
      m = d & 32'hF800_0000;
      nReg = (expReg & ~(m & 32'h9800_0000)) | (m & 32'h6000_0000);
      if (m[30]) nCnt = 0;
      nReq = m[30] | m[29];
    end
    @(posedge clk);
    expReg = nReg; expCnt = nCnt; expReq = nReq;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, 32'h0, 0, "");
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    cyc(0, 1, a, 32'h0, 0, req);
  endtask

  task automatic doPor();
    @(negedge clk);
    porN = 1'b0; busWr = 0; busRd = 0; evtForce = 0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    expReg = '0; expCnt = 0; expReq = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_1234);
    doPor();
    // R1: cleared after power-on
    rd(16'hF024, "R1");
    // R9: first event loads power-on code
    cyc(0, 0, 0, 0, 1, "");
    rd(16'hF024, "R9");
    // R2: low word and neighbour read zero
    rd(16'hF020, "R2");
    rd(16'hF02C, "R2");
    // R2: write to low word has no effect
    cyc(1, 0, 16'hF020, 32'hFFFF_FFFF, 0, "");
    rd(16'hF027, "R2");
    // R9: later event leaves register
    cyc(0, 0, 0, 0, 1, "");
    rd(16'hF024, "R9");
    // R4 R3: clear power-on, reserved bits ignored
    cyc(1, 0, 16'hF024, 32'h8FFF_FFFF, 0, "");
    rd(16'hF024, "R4");
    // R7 R5: soft externally-initiated, counter kept
    cyc(1, 0, 16'hF024, 32'h2000_0000, 0, "");
    idle(2);
    rd(16'hF024, "R5");
    cyc(0, 0, 0, 0, 1, "");
    rd(16'hF024, "R7");
    // R6: soft power-on rearms detection, looped back
    loopEn = 1'b1;
    cyc(1, 0, 16'hF024, 32'h4000_0000, 0, "");
    idle(2);
    rd(16'hF024, "R6");
    // R11: write with event in same cycle dropped
    cyc(1, 0, 16'hF024, 32'hE000_0000, 1, "");
    idle(2);
    rd(16'hF024, "R11");
    // R10: saturation, no false power-on
    loopEn = 1'b0;
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1, "");
    cyc(1, 0, 16'hF024, 32'h9800_0000, 0, "");
    cyc(0, 0, 0, 0, 1, "");
    rd(16'hF024, "R10");
    // R1: power-on mid-run
    doPor();
    rd(16'hF024, "R1");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [31:0] d;
      int sel;
      if (i % 200 == 0) loopEn = $urandom_range(1, 0);
      sel = $urandom_range(3, 0);
      case (sel)
        0: a = 16'hF024 | 16'($urandom_range(3, 0));
        1: a = 16'hF020 | 16'($urandom_range(3, 0));
        2: a = 16'($urandom);
        default: a = 16'hF02C;
      endcase
      d = $urandom;
      if ($urandom_range(3, 0) != 0) d = d & 32'h9FFF_FFFF;
      cyc($urandom_range(1, 0), $urandom_range(1, 0), a, d,
          ($urandom_range(15, 0) == 0), "R9 R4 R5");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule